// File: doc/BRIEF.md
# UART Modem Control Loopback

This block is the loopback path behind a UART control register. Software writes a control word that carries a loopback-enable bit and four modem control outputs (DTR, RTS, Out1, Out2). While loopback is on, each control write copies those outputs onto the modem status flags crosswise and rebuilds the four modem interrupt bits from the new flag levels. Characters written to the data register and a rising send-break request are turned back into the receive push path instead of the line. Characters arriving from the external receiver are thrown away for as long as loopback is on.

The block sits between a simple register write port and the receive buffer. It keeps the modem flags, the interrupt levels for the modem group and the transmit event, and a one-entry registered receive push. Serial bit timing and hardware flow control are not part of it. Every result of a write appears on the outputs one clock after the write is sampled.

Top module: `uart_mdm_loop`

## Requirements
- R1: After reset, `modem_flags`, `irq_level` and `rx_push_valid` are all zero, and loopback and send-break are off.
- R2: A control write (address 2) with bit 7 set makes, on the next cycle, flag bit 8 (ring) equal to control bit 13, flag bit 2 (carrier) equal to bit 12, flag bit 0 (CTS) equal to bit 11 and flag bit 1 (DSR) equal to bit 10; this holds for a write that only sets bit 7.
- R3: On such a write, the modem interrupt bits `irq_level[3:0]` (bit 0 ring, bit 1 CTS, bit 2 carrier, bit 3 DSR) are first all cleared and each is set again only if its flag is now high.
- R4: A control write with bit 7 clear leaves `modem_flags` and `irq_level[3:0]` unchanged.
- R5: A data write (address 0) while loopback is on pushes `{3'b000, data[7:0]}` on the next cycle; with loopback off a data write pushes nothing.
- R6: Every data write sets the transmit interrupt `irq_level[4]` on the next cycle, whatever the loopback state.
- R7: A line-control write (address 1) that changes send-break (bit 0) from 0 to 1 while loopback is on pushes the break value 0x400; a write that leaves the bit at 1 or clears it pushes nothing.
- R8: An external character is pushed on the next cycle when loopback was off before that cycle, and dropped when loopback was on.
- R9: A write to address 3 clears every `irq_level` bit whose write data bit is 1 and leaves the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 line control, 2 control, 3 interrupt clear |
| wr_data | input | 32 | Write data |
| ext_rx_valid | input | 1 | External receiver has a character |
| ext_rx_char | input | 8 | External received character |
| rx_push_valid | output | 1 | Push into the receive buffer |
| rx_push_data | output | 11 | Pushed entry, bit 10 marks break |
| modem_flags | output | 9 | Flag register modem bits: 0 CTS, 1 DSR, 2 carrier, 8 ring |
| irq_level | output | 5 | Raw interrupt levels: 0 ring, 1 CTS, 2 carrier, 3 DSR, 4 transmit |

## Verification
The bench goes after the crosswise mapping with one-hot control words, where a straight-through wiring would light CTS for DTR or carrier for Out2. It writes only the loopback-enable bit after the interrupt bits were left set, which a design that ORs rather than rebuilds the group would keep high. It disables loopback with new modem bits to catch flags that keep following the control word, repeats a break write to catch a level-triggered break push, and sends external characters in the cycle that turns loopback on, where the old state must decide.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
    // control word bit positions
    localparam int CTRL_LBE  = 7;
    localparam int CTRL_DTR  = 10;
    localparam int CTRL_RTS  = 11;
    localparam int CTRL_OUT1 = 12;
    localparam int CTRL_OUT2 = 13;
    // flag register positions
    localparam int FLG_CTS = 0;
    localparam int FLG_DSR = 1;
    localparam int FLG_DCD = 2;
    localparam int FLG_RI  = 8;
    // line control
    localparam int LINE_BRK = 0;
    // interrupt level positions
    localparam int IRQ_TX = 4;
    localparam int N_MDM  = 4;
    // index i of the modem group: 0 ring, 1 CTS, 2 carrier, 3 DSR
    localparam int MAP_SRC [N_MDM] = '{CTRL_OUT2, CTRL_RTS, CTRL_OUT1, CTRL_DTR};
    localparam int MAP_FLG [N_MDM] = '{FLG_RI, FLG_CTS, FLG_DCD, FLG_DSR};

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_LINE = 2'd1,
        A_CTRL = 2'd2,
        A_ICLR = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/uart_mdm_map.sv
module uart_mdm_map
    import uart_mdm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ctrl_word,
    output logic [N_MDM-1:0]  lvl
);
    for (genvar i = 0; i < N_MDM; i++) begin : g_src
        assign lvl[i] = ctrl_word[MAP_SRC[i]];
    end
endmodule

// File: rtl/uart_flag_pack.sv
module uart_flag_pack
    import uart_mdm_pkg::*;
#(
    parameter int FLAG_W = 9
) (
    input  logic [N_MDM-1:0]  lvl,
    output logic [FLAG_W-1:0] flags
);
    always_comb begin
        flags = '0;
        for (int i = 0; i < N_MDM; i++) begin
            flags[MAP_FLG[i]] = lvl[i];
        end
    end
endmodule

// File: rtl/uart_push_sel.sv
module uart_push_sel #(
    parameter int CHAR_W = 8,
    parameter int PUSH_W = 11
) (
    input  logic              lb_data_v,
    input  logic [CHAR_W-1:0] lb_char,
    input  logic              lb_brk_v,
    input  logic              ext_v,
    input  logic [CHAR_W-1:0] ext_char,
    output logic              push_v,
    output logic [PUSH_W-1:0] push_d
);
    localparam logic [PUSH_W-1:0] BRK_VAL = PUSH_W'(1) << (PUSH_W - 1);

    always_comb begin
        push_v = lb_data_v | lb_brk_v | ext_v;
        if (lb_data_v)      push_d = PUSH_W'(lb_char);
        else if (lb_brk_v)  push_d = BRK_VAL;
        else if (ext_v)     push_d = PUSH_W'(ext_char);
        else                push_d = '0;
    end
endmodule

// File: rtl/uart_mdm_loop.sv
module uart_mdm_loop
    import uart_mdm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8,
    parameter int PUSH_W = 11,
    parameter int FLAG_W = 9,
    parameter int IRQ_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_rx_valid,
    input  logic [CHAR_W-1:0] ext_rx_char,
    output logic              rx_push_valid,
    output logic [PUSH_W-1:0] rx_push_data,
    output logic [FLAG_W-1:0] modem_flags,
    output logic [IRQ_W-1:0]  irq_level
);
    typedef struct packed {
        logic              lbe;
        logic              brk;
        logic [N_MDM-1:0]  mdm;
        logic [IRQ_W-1:0]  irq;
        logic              push_v;
        logic [PUSH_W-1:0] push_d;
    } st_t;

    st_t st_d, st_q;

    logic ctrl_wr, data_wr, line_wr, clr_wr;
    logic [N_MDM-1:0] map_lvl;
    logic sel_v;
    logic [PUSH_W-1:0] sel_d;

    assign data_wr = wr_valid && (wr_addr == ADDR_W'(A_DATA));
    assign line_wr = wr_valid && (wr_addr == ADDR_W'(A_LINE));
    assign ctrl_wr = wr_valid && (wr_addr == ADDR_W'(A_CTRL));
    assign clr_wr  = wr_valid && (wr_addr == ADDR_W'(A_ICLR));

    uart_mdm_map #(.DATA_W(DATA_W)) u_map (
        .ctrl_word (wr_data),
        .lvl       (map_lvl)
    );

    uart_push_sel #(.CHAR_W(CHAR_W), .PUSH_W(PUSH_W)) u_sel (
        .lb_data_v (data_wr && st_q.lbe),
        .lb_char   (wr_data[CHAR_W-1:0]),
        .lb_brk_v  (line_wr && st_q.lbe && !st_q.brk && wr_data[LINE_BRK]),
        .ext_v     (ext_rx_valid && !st_q.lbe),
        .ext_char  (ext_rx_char),
        .push_v    (sel_v),
        .push_d    (sel_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.push_v = sel_v;
        st_d.push_d = sel_d;
        if (ctrl_wr) begin
            st_d.lbe = wr_data[CTRL_LBE];
            if (wr_data[CTRL_LBE]) begin
                st_d.mdm              = map_lvl;
                st_d.irq[N_MDM-1:0]   = map_lvl;
            end
        end
        if (line_wr) st_d.brk = wr_data[LINE_BRK];
        if (data_wr) st_d.irq[IRQ_TX] = 1'b1;
        if (clr_wr)  st_d.irq = st_q.irq & ~wr_data[IRQ_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_flag_pack #(.FLAG_W(FLAG_W)) u_pack (
        .lvl   (st_q.mdm),
        .flags (modem_flags)
    );

    assign rx_push_valid = st_q.push_v;
    assign rx_push_data  = st_q.push_d;
    assign irq_level     = st_q.irq;
endmodule

// File: rtl/uart_mdm_loop_chk.sv
module uart_mdm_loop_chk
    import uart_mdm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8,
    parameter int PUSH_W = 11,
    parameter int FLAG_W = 9,
    parameter int IRQ_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              ext_rx_valid,
    input logic [CHAR_W-1:0] ext_rx_char,
    input logic              rx_push_valid,
    input logic [PUSH_W-1:0] rx_push_data,
    input logic [FLAG_W-1:0] modem_flags,
    input logic [IRQ_W-1:0]  irq_level
);
    logic c_data, c_line, c_ctrl, c_clr;
    logic lbe_sh, brk_sh;

    assign c_data = wr_valid && wr_addr == ADDR_W'(A_DATA);
    assign c_line = wr_valid && wr_addr == ADDR_W'(A_LINE);
    assign c_ctrl = wr_valid && wr_addr == ADDR_W'(A_CTRL);
    assign c_clr  = wr_valid && wr_addr == ADDR_W'(A_ICLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbe_sh <= 1'b0;
            brk_sh <= 1'b0;
        end else begin
            if (c_ctrl) lbe_sh <= wr_data[CTRL_LBE];
            if (c_line) brk_sh <= wr_data[LINE_BRK];
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_level == '0 && modem_flags == '0 && !rx_push_valid));

    p_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl && wr_data[CTRL_LBE] |=>
            modem_flags[FLG_RI]  == $past(wr_data[CTRL_OUT2]) &&
            modem_flags[FLG_DCD] == $past(wr_data[CTRL_OUT1]) &&
            modem_flags[FLG_CTS] == $past(wr_data[CTRL_RTS]) &&
            modem_flags[FLG_DSR] == $past(wr_data[CTRL_DTR]));

    p_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl && wr_data[CTRL_LBE] |=>
            irq_level[3:0] == {$past(wr_data[CTRL_DTR]), $past(wr_data[CTRL_OUT1]),
                               $past(wr_data[CTRL_RTS]), $past(wr_data[CTRL_OUT2])});

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl && !wr_data[CTRL_LBE] |=>
            $stable(modem_flags) && irq_level[3:0] == $past(irq_level[3:0]));

    p_loop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_data && lbe_sh |=>
            rx_push_valid && rx_push_data == PUSH_W'($past(wr_data[CHAR_W-1:0])));

    p_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_data && !lbe_sh && !ext_rx_valid |=> !rx_push_valid);

    p_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_data |=> irq_level[IRQ_TX]);

    p_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_line && lbe_sh && !brk_sh && wr_data[LINE_BRK] |=>
            rx_push_valid && rx_push_data == PUSH_W'(1) << (PUSH_W - 1));

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rx_valid && lbe_sh && !wr_valid |=> !rx_push_valid);

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rx_valid && !lbe_sh |=>
            rx_push_valid && rx_push_data == PUSH_W'($past(ext_rx_char)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> (irq_level & $past(wr_data[IRQ_W-1:0])) == '0);
endmodule

bind uart_mdm_loop uart_mdm_loop_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
    .PUSH_W(PUSH_W), .FLAG_W(FLAG_W), .IRQ_W(IRQ_W)
) u_chk (.*);

// File: tb/uart_mdm_loop_bench.sv
`timescale 1ns/1ps
module uart_mdm_loop_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ext_rx_valid = 1'b0;
    logic [7:0]  ext_rx_char = '0;
    logic        rx_push_valid;
    logic [10:0] rx_push_data;
    logic [8:0]  modem_flags;
    logic [4:0]  irq_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit       m_lbe, m_brk;
    bit [3:0] m_mdm;   // 0 ring, 1 CTS, 2 carrier, 3 DSR
    bit [4:0] m_irq;

    always #4 clk = ~clk;

    uart_mdm_loop u_uart_mdm_loop (
        .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .ext_rx_valid,
        .ext_rx_char, .rx_push_valid, .rx_push_data, .modem_flags, .irq_level
    );

    function automatic bit [8:0] flags_of(bit [3:0] m);
        bit [8:0] f = '0;
        f[8] = m[0]; f[0] = m[1]; f[2] = m[2]; f[1] = m[3];
        return f;
    endfunction

    function automatic bit [3:0] group_of(bit [31:0] c);
        return {c[10], c[12], c[11], c[13]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one operation; called right after a negedge
    task automatic op(bit wv, bit [1:0] a, bit [31:0] d, bit ev, bit [7:0] ec, string req);
        bit        e_pv = 0;
        bit [10:0] e_pd = '0;
        if (wv && a == 2'd0 && m_lbe) begin e_pv = 1; e_pd = {3'b000, d[7:0]}; end
        else if (wv && a == 2'd1 && m_lbe && !m_brk && d[0]) begin e_pv = 1; e_pd = 11'h400; end
        else if (ev && !m_lbe) begin e_pv = 1; e_pd = {3'b000, ec}; end
        if (wv) case (a)
            2'd0: m_irq[4] = 1;
            2'd1: m_brk = d[0];
            2'd2: begin
                m_lbe = d[7];
                if (d[7]) begin m_mdm = group_of(d); m_irq[3:0] = group_of(d); end
            end
            default: m_irq = m_irq & ~d[4:0];
        endcase
        wr_valid = wv; wr_addr = a; wr_data = d;
        ext_rx_valid = ev; ext_rx_char = ec;
        @(negedge clk);
        wr_valid = 0; ext_rx_valid = 0;
        chk({req, " flags"}, 32'(modem_flags), 32'(flags_of(m_mdm)));
        chk({req, " irq"}, 32'(irq_level), 32'(m_irq));
        chk({req, " push"}, {20'h0, rx_push_valid, rx_push_data}, {20'h0, e_pv, e_pd});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", 32'(modem_flags), 0);
        chk("R1 irq", 32'(irq_level), 0);
        chk("R1 push", 32'(rx_push_valid), 0);
        // R8 external char passes with loopback off
        op(0, 0, 0, 1, 8'h5A, "R8 pass");
        // R6 data write with loopback off: tx irq, no push (R5)
        op(1, 0, 32'h41, 0, 0, "R6 R5 off");
        // R2 R3 all modem bits with loopback
        op(1, 2, 32'h3C80, 0, 0, "R2 R3 all");
        // R2 R3 one-hot words test the crosswise mapping
        op(1, 2, 32'h2080, 0, 0, "R2 out2");
        op(1, 2, 32'h1080, 0, 0, "R2 out1");
        op(1, 2, 32'h0880, 0, 0, "R2 rts");
        op(1, 2, 32'h0480, 0, 0, "R2 dtr");
        // R4 loopback off, modem bits ignored
        op(1, 2, 32'h3800, 0, 0, "R4 hold");
        // R9 clear then R3 loopback-only write rebuilds group from zero levels
        op(1, 3, 32'h1F, 0, 0, "R9 clr");
        op(1, 2, 32'h0880, 1, 8'h77, "R8 old state");
        op(1, 2, 32'h0080, 0, 0, "R3 lbe only");
        // R5 data loopback, R8 drop
        op(1, 0, 32'hFFA5, 0, 0, "R5 loop");
        op(0, 0, 0, 1, 8'h33, "R8 drop");
        // R7 break rise, repeat, fall
        op(1, 1, 32'h1, 0, 0, "R7 rise");
        op(1, 1, 32'h1, 0, 0, "R7 repeat");
        op(1, 1, 32'h0, 0, 0, "R7 fall");
        op(1, 3, 32'h10, 0, 0, "R9 tx");
        // random mix
        for (int i = 0; i < 400; i++) begin
            bit [31:0] d = $urandom;
            bit [2:0]  k = 3'($urandom % 5);
            bit        ev = 1'($urandom);
            bit [7:0]  ec = 8'($urandom);
            if (k == 3'd2) d[7] = 1'($urandom % 4 != 0);
            if (k == 3'd4) op(0, 0, 0, ev, ec, "R5 R8 rand");
            else           op(1, k[1:0], d, ev, ec, "R2 R9 rand");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule